// File: doc/BRIEF.md
# Front-to-Back Ray Compositor

This block accumulates shaded, classified samples along viewing rays into a one-slice base-plane buffer. Each cycle it may take one sample: a 6-bit-per-channel RGB colour, an 8-bit sample value that picks an opacity from a loadable classification table, the base-plane pixel position, and control flags. It fetches the partial result kept for that pixel and blends the new sample behind what is already there (front-to-back order). The result then goes back into the same buffer entry. Samples arrive slice by slice, so each pixel's entry is revisited once per slice.

When a sample carries either wrap flag, it is the last sample of its ray. The finished pixel then leaves the block with its x and y address, and the entry returns to transparent black for the next ray. A sample flagged invalid changes nothing. A start flag makes a sample ignore whatever its entry held before. The pipeline has two register stages. A read that would miss a write still in flight takes the in-flight value instead, so samples for the same pixel may arrive on consecutive cycles.

Top module: `ray_compositor`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `out_valid` is 0. After reset every buffer entry holds transparent black (all channels and alpha zero).
- R2: A write with `tbl_we` high stores `tbl_data` at index `tbl_addr`. A later sample with value v uses bits [31:25] of entry v as its opacity a, a 7-bit value from 0 to 127.
- R3: A sample with opacity a, blended onto stored colour C and alpha A (A in 0..127), gives w = ((127-A)*a + 64) >> 7, A' = min(127, A+w) and, per channel, C' = min(63, C + ((w*c + 64) >> 7)).
- R4: A sample whose opacity is 0 leaves the entry's colour and alpha unchanged.
- R5: Each pixel keeps its own entry. Samples for different pixels may interleave in any order, and each pixel accumulates only its own samples.
- R6: Samples for the same pixel on consecutive cycles blend as if each had seen the result of the one before.
- R7: A sample with `in_forget` high leaves its entry unchanged and produces no output, even if it also carries a wrap flag.
- R8: A sample with `in_start` high blends onto transparent black, whatever its entry held before.
- R9: A valid, non-forgotten sample with `in_xwrap` or `in_ywrap` high emits the blended pixel and its x, y on the outputs. Its entry then holds transparent black.
- R10: The output for a sample presented on cycle t appears on cycle t+2. `out_valid` is high only for such last samples and is high for every one of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_we | input | 1 | Opacity table write enable |
| tbl_addr | input | 8 | Opacity table write index |
| tbl_data | input | 32 | Opacity table entry; bits [31:25] are the opacity |
| in_valid | input | 1 | Sample present this cycle |
| in_r | input | 6 | Sample red |
| in_g | input | 6 | Sample green |
| in_b | input | 6 | Sample blue |
| in_val | input | 8 | Sample value, opacity table index |
| in_x | input | 4 | Base-plane x |
| in_y | input | 4 | Base-plane y |
| in_start | input | 1 | Ignore previous entry contents |
| in_forget | input | 1 | Sample is invalid, discard it |
| in_xwrap | input | 1 | Last sample of ray (x wrap) |
| in_ywrap | input | 1 | Last sample of ray (y wrap) |
| out_valid | output | 1 | Finished pixel present |
| out_r | output | 6 | Pixel red |
| out_g | output | 6 | Pixel green |
| out_b | output | 6 | Pixel blue |
| out_a | output | 7 | Pixel accumulated opacity |
| out_x | output | 4 | Pixel base-plane x |
| out_y | output | 4 | Pixel base-plane y |

## Verification
The assertions check the output timing and gating on every cycle. They confirm that a finished pixel appears exactly two cycles after a valid, non-forgotten last sample and never at any other time, that forgotten samples stay silent, that the emitted address matches the sample's, and that no output appears on the cycle after reset. The blend values cannot be checked this way. Accumulation across slices, forwarding between back-to-back samples to one pixel, entry clearing after emission and the effect of the start flag are only visible in the bench scenarios. There, emitted colours and alpha are compared against a reference model of the buffer.

// File: rtl/ray_compositor.sv
module ray_compositor #(
  parameter int XW = 4,
  parameter int YW = 4,
  parameter int CW = 6,
  parameter int AW = 7,
  parameter int VW = 8,
  parameter int TW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tbl_we,
  input  logic [VW-1:0] tbl_addr,
  input  logic [TW-1:0] tbl_data,
  input  logic          in_valid,
  input  logic [CW-1:0] in_r,
  input  logic [CW-1:0] in_g,
  input  logic [CW-1:0] in_b,
  input  logic [VW-1:0] in_val,
  input  logic [XW-1:0] in_x,
  input  logic [YW-1:0] in_y,
  input  logic          in_start,
  input  logic          in_forget,
  input  logic          in_xwrap,
  input  logic          in_ywrap,
  output logic          out_valid,
  output logic [CW-1:0] out_r,
  output logic [CW-1:0] out_g,
  output logic [CW-1:0] out_b,
  output logic [AW-1:0] out_a,
  output logic [XW-1:0] out_x,
  output logic [YW-1:0] out_y
);
  localparam int PW    = XW + YW;
  localparam int DEPTH = 1 << PW;
  localparam int TD    = 1 << VW;
  localparam int EW    = 3 * CW + AW;
  localparam int WPW   = 2 * AW + 1;
  localparam int CPW   = AW + CW + 1;
  localparam logic [AW-1:0] AMAX = '1;
  localparam int HALF  = 1 << (AW - 1);

  logic [AW-1:0] optab [TD];
  logic [EW-1:0] pbuf  [DEPTH];

  logic          tbl_unused;
  assign tbl_unused = ^tbl_data[TW-AW-1:0];

  logic          s_v, s_start, s_forget, s_last;
  logic [CW-1:0] s_r, s_g, s_b;
  logic [AW-1:0] s_op;
  logic [PW-1:0] s_addr;
  logic [EW-1:0] s_prev;

  logic [EW-1:0] base, blended, wr_data;
  logic [AW-1:0] ba, w, na;
  logic [WPW-1:0] wprod;
  logic [AW:0]   asum;
  logic          wr_en;
  logic [PW-1:0] in_addr;

  function automatic logic [CW-1:0] mix(input logic [CW-1:0] acc,
                                        input logic [CW-1:0] c,
                                        input logic [AW-1:0] wt);
    logic [CPW-1:0] p;
    logic [CW:0]    s;
    p = CPW'(wt) * CPW'(c) + CPW'(HALF);
    s = (CW+1)'(acc) + (CW+1)'(p >> AW);
    return s[CW] ? '1 : s[CW-1:0];
  endfunction

  assign in_addr = {in_y, in_x};
  assign base    = s_start ? '0 : s_prev;
  assign ba      = base[AW-1:0];
  assign wprod   = WPW'(AMAX - ba) * WPW'(s_op) + WPW'(HALF);
  assign w       = AW'(wprod >> AW);
  assign asum    = (AW+1)'(ba) + (AW+1)'(w);
  assign na      = asum[AW] ? AMAX : asum[AW-1:0];
  assign blended = {mix(base[EW-1 -: CW], s_r, w),
                    mix(base[EW-CW-1 -: CW], s_g, w),
                    mix(base[EW-2*CW-1 -: CW], s_b, w), na};
  assign wr_en   = s_v && !s_forget;
  assign wr_data = s_last ? '0 : blended;

  always_ff @(posedge clk) begin
    if (tbl_we) optab[tbl_addr] <= tbl_data[TW-1 -: AW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) pbuf[i] <= '0;
    end else if (wr_en) begin
      pbuf[s_addr] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_v <= 1'b0; s_start <= 1'b0; s_forget <= 1'b0; s_last <= 1'b0;
      s_r <= '0; s_g <= '0; s_b <= '0; s_op <= '0; s_addr <= '0; s_prev <= '0;
    end else begin
      s_v      <= in_valid;
      s_start  <= in_start;
      s_forget <= in_forget;
      s_last   <= in_xwrap | in_ywrap;
      s_r      <= in_r;
      s_g      <= in_g;
      s_b      <= in_b;
      s_op     <= optab[in_val];
      s_addr   <= in_addr;
      s_prev   <= (wr_en && s_addr == in_addr) ? wr_data : pbuf[in_addr];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_r <= '0; out_g <= '0; out_b <= '0; out_a <= '0;
      out_x <= '0; out_y <= '0;
    end else begin
      out_valid <= wr_en && s_last;
      out_r     <= blended[EW-1 -: CW];
      out_g     <= blended[EW-CW-1 -: CW];
      out_b     <= blended[EW-2*CW-1 -: CW];
      out_a     <= blended[AW-1:0];
      out_x     <= s_addr[XW-1:0];
      out_y     <= s_addr[PW-1 -: YW];
    end
  end
endmodule

// File: rtl/ray_compositor_chk.sv
module ray_compositor_chk #(
  parameter int XW = 4,
  parameter int YW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_forget,
  input logic          in_xwrap,
  input logic          in_ywrap,
  input logic [XW-1:0] in_x,
  input logic [YW-1:0] in_y,
  input logic          out_valid,
  input logic [XW-1:0] out_x,
  input logic [YW-1:0] out_y
);
  logic last_ok;
  assign last_ok = in_valid && (in_xwrap || in_ywrap) && !in_forget;

  p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> !out_valid);

  p_forget_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid && in_forget, 2) |-> !out_valid);

  p_emit_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_x == $past(in_x, 2)) && (out_y == $past(in_y, 2)));

  p_emit_only_last_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(last_ok, 2));

  p_emit_every_last_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n, 2) && $past(rst_n) && $past(last_ok, 2)) |-> out_valid);
endmodule

bind ray_compositor ray_compositor_chk #(.XW(XW), .YW(YW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_forget(in_forget),
  .in_xwrap(in_xwrap), .in_ywrap(in_ywrap), .in_x(in_x), .in_y(in_y),
  .out_valid(out_valid), .out_x(out_x), .out_y(out_y)
);

// File: tb/ray_compositor_tb.sv
module ray_compositor_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tbl_we = 1'b0;
  logic [7:0] tbl_addr = '0;
  logic [31:0] tbl_data = '0;
  logic in_valid = 1'b0;
  logic [5:0] in_r = '0, in_g = '0, in_b = '0;
  logic [7:0] in_val = '0;
  logic [3:0] in_x = '0, in_y = '0;
  logic in_start = 1'b0, in_forget = 1'b0, in_xwrap = 1'b0, in_ywrap = 1'b0;
  logic out_valid;
  logic [5:0] out_r, out_g, out_b;
  logic [6:0] out_a;
  logic [3:0] out_x, out_y;

  always #(CLK_PERIOD/2) clk = ~clk;

  ray_compositor u_dut (
    .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_data(tbl_data),
    .in_valid(in_valid), .in_r(in_r), .in_g(in_g), .in_b(in_b), .in_val(in_val),
    .in_x(in_x), .in_y(in_y), .in_start(in_start), .in_forget(in_forget),
    .in_xwrap(in_xwrap), .in_ywrap(in_ywrap), .out_valid(out_valid),
    .out_r(out_r), .out_g(out_g), .out_b(out_b), .out_a(out_a),
    .out_x(out_x), .out_y(out_y)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;
  int tmod [256];
  int mr [256], mg [256], mb [256], ma [256];

  bit pv0, pv1;
  int pr0, pg0, pb0, pa0, px0, py0, pr1, pg1, pb1, pa1, px1, py1;
  string pt0 = "", pt1 = "";

  function automatic int sat(input int v, input int mx);
    return (v > mx) ? mx : v;
  endfunction

  task automatic chk(input string tag, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  task automatic step(input bit v, input int x, input int y, input int r, input int g,
                      input int b, input int val, input bit st, input bit fg,
                      input bit lst, input string tag);
    int idx, w, cr, cg, cb, ca, op;
    @(negedge clk);
    chk(pt1, "out_valid", int'(out_valid), int'(pv1));
    if (pv1) begin
      chk(pt1, "out_r", int'(out_r), pr1);
      chk(pt1, "out_g", int'(out_g), pg1);
      chk(pt1, "out_b", int'(out_b), pb1);
      chk(pt1, "out_a", int'(out_a), pa1);
      chk(pt1, "out_x", int'(out_x), px1);
      chk(pt1, "out_y", int'(out_y), py1);
    end
    pv1 = pv0; pr1 = pr0; pg1 = pg0; pb1 = pb0; pa1 = pa0; px1 = px0; py1 = py0; pt1 = pt0;
    in_valid = v; in_x = 4'(x); in_y = 4'(y); in_r = 6'(r); in_g = 6'(g); in_b = 6'(b);
    in_val = 8'(val); in_start = st; in_forget = fg;
    in_xwrap = lst & x[0]; in_ywrap = lst & ~x[0];
    pv0 = 1'b0; pt0 = tag;
    if (v && !fg) begin
      idx = y * 16 + x;
      op = tmod[val] >> 25;
      if (st) begin cr = 0; cg = 0; cb = 0; ca = 0; end
      else begin cr = mr[idx]; cg = mg[idx]; cb = mb[idx]; ca = ma[idx]; end
      w  = ((127 - ca) * op + 64) >> 7;
      cr = sat(cr + ((w * r + 64) >> 7), 63);
      cg = sat(cg + ((w * g + 64) >> 7), 63);
      cb = sat(cb + ((w * b + 64) >> 7), 63);
      ca = sat(ca + w, 127);
      if (lst) begin
        pv0 = 1'b1; pr0 = cr; pg0 = cg; pb0 = cb; pa0 = ca; px0 = x; py0 = y;
        mr[idx] = 0; mg[idx] = 0; mb[idx] = 0; ma[idx] = 0;
      end else begin
        mr[idx] = cr; mg[idx] = cg; mb[idx] = cb; ma[idx] = ca;
      end
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R10");
  endtask

  task automatic load(input int a, input int d);
    @(negedge clk);
    tbl_we = 1'b1; tbl_addr = 8'(a); tbl_data = 32'(d); tmod[a] = d;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) begin mr[i] = 0; mg[i] = 0; mb[i] = 0; ma[i] = 0; end
    pv0 = 0; pv1 = 0;
    repeat (3) @(negedge clk);
    chk("R1", "out_valid in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "out_valid after reset", int'(out_valid), 0);

    for (int i = 0; i < 256; i++) load(i, int'($urandom));
    load(1, 32'h01FF_FFFF);   // R4: opacity field 0
    load(2, 32'hFE00_0000);   // R2: opacity 127
    load(3, 32'h8000_0000);   // R2: opacity 64
    idle(3);

    // R1: untouched entry starts transparent black
    step(1, 2, 3, 40, 20, 10, 3, 0, 0, 1, "R1");
    // R2 / R3: full-opacity sample on a started ray
    step(1, 0, 0, 63, 31, 0, 2, 1, 0, 1, "R2");
    // R3: two slices, non-adjacent
    step(1, 1, 0, 50, 12, 33, 3, 1, 0, 0, "R3");
    idle(1);
    step(1, 1, 0, 20, 60, 5, 3, 0, 0, 1, "R3");
    // R6: back-to-back same pixel
    step(1, 5, 5, 10, 20, 30, 3, 1, 0, 0, "R6");
    step(1, 5, 5, 60, 40, 20, 3, 0, 0, 0, "R6");
    step(1, 5, 5, 33, 33, 33, 3, 0, 0, 1, "R6");
    // R5: interleaved pixels
    step(1, 3, 4, 60, 0, 0, 3, 1, 0, 0, "R5");
    step(1, 4, 3, 0, 60, 0, 2, 1, 0, 0, "R5");
    step(1, 3, 4, 0, 0, 60, 3, 0, 0, 0, "R5");
    step(1, 4, 3, 60, 0, 60, 3, 0, 0, 0, "R5");
    step(1, 3, 4, 30, 30, 30, 3, 0, 0, 1, "R5");
    step(1, 4, 3, 30, 30, 30, 3, 0, 0, 1, "R5");
    // R7: forgotten samples change nothing, forgotten last emits nothing
    step(1, 6, 6, 40, 40, 40, 3, 1, 0, 0, "R7");
    step(1, 6, 6, 63, 0, 0, 2, 0, 1, 0, "R7");
    step(1, 6, 6, 0, 63, 0, 2, 0, 1, 1, "R7");
    step(1, 6, 6, 10, 10, 10, 3, 0, 0, 1, "R7");
    // R4: zero opacity leaves entry unchanged
    step(1, 7, 7, 44, 22, 11, 3, 1, 0, 0, "R4");
    step(1, 7, 7, 63, 63, 63, 1, 0, 0, 0, "R4");
    step(1, 7, 7, 63, 63, 63, 1, 0, 0, 1, "R4");
    // R8: start discards accumulated contents
    step(1, 8, 8, 63, 63, 63, 3, 0, 0, 0, "R8");
    step(1, 8, 8, 63, 63, 63, 3, 0, 0, 0, "R8");
    step(1, 8, 8, 5, 15, 25, 2, 1, 0, 1, "R8");
    // R9: emission clears the entry
    step(1, 9, 9, 63, 63, 63, 2, 1, 0, 1, "R9");
    step(1, 9, 9, 20, 40, 60, 3, 0, 0, 1, "R9");
    idle(3);

    // R10: random traffic on a few pixels to provoke hazards
    for (int i = 0; i < 3000; i++) begin
      int px, py;
      px = int'($urandom_range(0, 2));
      py = int'($urandom_range(0, 1));
      step(($urandom_range(0, 3) != 0), px, py,
           int'($urandom_range(0, 63)), int'($urandom_range(0, 63)),
           int'($urandom_range(0, 63)), int'($urandom_range(0, 255)),
           ($urandom_range(0, 19) == 0), ($urandom_range(0, 9) == 0),
           ($urandom_range(0, 4) == 0), "R10");
    end
    idle(3);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule